// File: doc/BRIEF.md
# Inverter Leg Interlock and Dead-Interval Generator

This block sits between a PWM source and the gate drivers of one inverter half-bridge. It takes two active-low commands, one for the upper switch and one for the lower switch, and produces two registered gate-enable outputs. The two outputs are never on together. Whenever one output turns off, both stay low for a parameterised number of clock cycles before either may turn on. A global enable, a global fault line and a separate undervoltage flag for each supply side can all force the outputs off. The upper side has an arming rule: after reset, or after its supply undervoltage, it stays off until its command shows a new transition from inactive to active.

All inputs are asynchronous to the clock and pass through a synchroniser. All timing is counted in clock cycles. A three-phase driver uses three instances that share the enable and fault lines.

Top module: `leg_gate_guard`

## Requirements
- R1: During reset and after reset, with no command active, `hoOn` and `loOn` are both 0.
- R2: `hoOn` and `loOn` are never 1 in the same cycle. When both commands are 0 (active) for 4 cycles, both outputs are 0.
- R3: An output may turn on in the cycle its opposite turns off only if the opposite had been off for at least DEAD_CYC cycles. In a direct handoff, where one command is released and the opposite command is asserted in the same cycle, both outputs are 0 for exactly DEAD_CYC cycles between the falling edge of one output and the rising edge of the other.
- R4: After a conflict in which both commands are active, releasing one of them lets the other output turn on no sooner than DEAD_CYC and no later than DEAD_CYC+4 cycles after the release.
- R5: From idle, with the dead interval already elapsed, a lower command at 0 sets `loOn` within 4 cycles, and returning it to 1 clears `loOn` within 4 cycles. An armed upper command behaves the same way with `hoOn`, within 5 cycles.
- R6: While `enable` is 0, both outputs are 0 within 4 cycles. When `enable` returns to 1, the outputs follow the commands again after the dead interval.
- R7: While `fault` is 1, both outputs are 0 within 4 cycles. When `fault` clears, an armed upper side returns without needing a new command edge.
- R8: While `loUv` is 1, both outputs are 0. When it clears, `loOn` follows the level of `loCmdN` within 4 cycles, and no new edge is needed.
- R9: `hiUv` at 1 forces `hoOn` to 0 within 4 cycles and leaves `loOn` untouched. After it clears, `hoOn` stays 0 while `hiCmdN` is held at 0. It returns only after `hiCmdN` goes from 1 to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hiCmdN | input | 1 | Upper switch command, 0 requests on |
| loCmdN | input | 1 | Lower switch command, 0 requests on |
| enable | input | 1 | Global enable, 0 forces all outputs off |
| fault | input | 1 | Global fault or shutdown, 1 forces all outputs off |
| hiUv | input | 1 | Upper supply undervoltage, 1 forces the upper side off and disarms it |
| loUv | input | 1 | Lower supply undervoltage, 1 forces all outputs off |
| hoOn | output | 1 | Upper gate enable |
| loOn | output | 1 | Lower gate enable |

## Verification
A corrupted leg state or a wrong dead counter shows up at the ports as an opposite-side rise that comes one or more cycles early or late. The bench measures this gap exactly on every handoff, and the bound checker measures it on every rise. A lost or stuck arming flag shows up as `hoOn` returning after an upper undervoltage without a fresh command edge, or as `hoOn` never turning on at all. Either shows within a few cycles of the command. Shutdown paths are checked against a fixed four-cycle window, so a missing kill term is seen before the window closes.

// File: rtl/leg_pkg.sv
package leg_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_DEAD = 2'd1,
    LEG_HI   = 2'd2,
    LEG_LO   = 2'd3
  } legState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic deadLoad;
    logic hoNext;
    logic loNext;
  } legStrobe_t;

  // synchronised view of the leg returned to control
  typedef struct packed {
    logic hiAct;
    logic loAct;
    logic hiFall;
    logic hiUv;
    logic kill;
    logic deadDone;
  } legStatus_t;

endpackage

// File: rtl/leg_dp.sv
module leg_dp
  import leg_pkg::*;
#(
  parameter int DEAD_CYC    = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hiCmdN,
  input  logic       loCmdN,
  input  logic       enable,
  input  logic       fault,
  input  logic       hiUv,
  input  logic       loUv,
  input  legStrobe_t strobe,
  output legStatus_t status,
  output logic       hoOn,
  output logic       loOn
);

  localparam int NIN = 6;
  localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] DEAD_LOAD = CNT_W'(DEAD_CYC - 1);
  // bit order: hiCmdN, loCmdN, enable, fault, hiUv, loUv
  localparam logic [NIN-1:0] RST_VAL = 6'b000011;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncIn;
  assign rawIn = {loUv, hiUv, fault, enable, loCmdN, hiCmdN};

  for (genvar b = 0; b < NIN; b++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {SYNC_STAGES{RST_VAL[b]}};
      else        chain <= {chain[SYNC_STAGES-2:0], rawIn[b]};
    end
    assign syncIn[b] = chain[SYNC_STAGES-1];
  end

  logic hiCmdS, loCmdS, enS, faultS, hiUvS, loUvS;
  assign {loUvS, hiUvS, faultS, enS, loCmdS, hiCmdS} = syncIn;

  logic hiPrev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hiPrev <= 1'b1;
    else        hiPrev <= hiCmdS;
  end

  logic [CNT_W-1:0] deadCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                deadCnt <= '0;
    else if (strobe.deadLoad)  deadCnt <= DEAD_LOAD;
    else if (deadCnt != '0)    deadCnt <= deadCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoOn <= 1'b0;
      loOn <= 1'b0;
    end else begin
      hoOn <= strobe.hoNext;
      loOn <= strobe.loNext;
    end
  end

  always_comb begin
    status.hiAct    = ~hiCmdS;
    status.loAct    = ~loCmdS;
    status.hiFall   = hiPrev & ~hiCmdS;
    status.hiUv     = hiUvS;
    status.kill     = faultS | ~enS | loUvS;
    status.deadDone = (deadCnt == '0);
  end

endmodule

// File: rtl/leg_ctrl.sv
module leg_ctrl
  import leg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  legStatus_t status,
  output legStrobe_t strobe
);

  legState_e state, stateNext;
  logic hiArmed, hiArmedNext;
  logic conflict, hiWant, loWant, deadLoad;

  always_comb begin
    conflict = status.hiAct & status.loAct;
    hiWant   = status.hiAct & ~status.loAct & hiArmed & ~status.hiUv & ~status.kill;
    loWant   = status.loAct & ~status.hiAct & ~status.kill;
  end

  always_comb begin
    if (status.hiUv)        hiArmedNext = 1'b0;
    else if (status.hiFall) hiArmedNext = 1'b1;
    else                    hiArmedNext = hiArmed;
  end

  always_comb begin
    stateNext = state;
    deadLoad  = 1'b0;
    unique case (state)
      LEG_OFF: begin
        if (conflict) begin
          stateNext = LEG_DEAD;
          deadLoad  = 1'b1;
        end else if (hiWant) stateNext = LEG_HI;
        else if (loWant)     stateNext = LEG_LO;
      end
      LEG_HI: begin
        if (!hiWant) begin
          stateNext = LEG_DEAD;
          deadLoad  = 1'b1;
        end
      end
      LEG_LO: begin
        if (!loWant) begin
          stateNext = LEG_DEAD;
          deadLoad  = 1'b1;
        end
      end
      LEG_DEAD: begin
        if (conflict) deadLoad = 1'b1;
        else if (status.deadDone) begin
          if (hiWant)      stateNext = LEG_HI;
          else if (loWant) stateNext = LEG_LO;
          else             stateNext = LEG_OFF;
        end
      end
      default: stateNext = LEG_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LEG_OFF;
      hiArmed <= 1'b0;
    end else begin
      state   <= stateNext;
      hiArmed <= hiArmedNext;
    end
  end

  always_comb begin
    strobe.deadLoad = deadLoad;
    strobe.hoNext   = (stateNext == LEG_HI);
    strobe.loNext   = (stateNext == LEG_LO);
  end

endmodule

// File: rtl/leg_gate_guard.sv
module leg_gate_guard
  import leg_pkg::*;
#(
  parameter int DEAD_CYC    = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hiCmdN,
  input  logic loCmdN,
  input  logic enable,
  input  logic fault,
  input  logic hiUv,
  input  logic loUv,
  output logic hoOn,
  output logic loOn
);

  legStrobe_t strobe;
  legStatus_t status;

  leg_dp #(.DEAD_CYC(DEAD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .hiCmdN(hiCmdN), .loCmdN(loCmdN), .enable(enable), .fault(fault),
    .hiUv(hiUv), .loUv(loUv),
    .strobe(strobe), .status(status),
    .hoOn(hoOn), .loOn(loOn)
  );

  leg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .status(status), .strobe(strobe)
  );

endmodule

// File: rtl/leg_gate_guard_chk.sv
module leg_gate_guard_chk #(
  parameter int DEAD_CYC = 38
) (
  input logic clk,
  input logic rst_n,
  input logic hiCmdN,
  input logic loCmdN,
  input logic enable,
  input logic fault,
  input logic hiUv,
  input logic loUv,
  input logic hoOn,
  input logic loOn
);

  localparam int GW = $clog2(DEAD_CYC + 2);

  logic [GW-1:0] hoGap, loGap;
  logic kill, clash;
  assign kill  = fault | ~enable | loUv;
  assign clash = ~hiCmdN & ~loCmdN;

  // cycles each output has been low, saturating at DEAD_CYC
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoGap <= GW'(DEAD_CYC);
      loGap <= GW'(DEAD_CYC);
    end else begin
      if (hoOn) hoGap <= '0;
      else if (hoGap < GW'(DEAD_CYC)) hoGap <= hoGap + 1'b1;
      if (loOn) loGap <= '0;
      else if (loGap < GW'(DEAD_CYC)) loGap <= loGap + 1'b1;
    end
  end

  assert_never_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hoOn && loOn));

  assert_clash_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clash && $past(clash) && $past(clash, 2) && $past(clash, 3) |-> !hoOn && !loOn);

  assert_dead_before_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hoOn) |-> loGap >= GW'(DEAD_CYC));

  assert_dead_before_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loOn) |-> hoGap >= GW'(DEAD_CYC));

  // R6, R7 and R8 share one shutdown window
  assert_kill_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill && $past(kill) && $past(kill, 2) && $past(kill, 3) |-> !hoOn && !loOn);

  assert_hiuv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hiUv && $past(hiUv) && $past(hiUv, 2) && $past(hiUv, 3) |-> !hoOn);

endmodule

bind leg_gate_guard leg_gate_guard_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hiCmdN(hiCmdN), .loCmdN(loCmdN),
  .enable(enable), .fault(fault), .hiUv(hiUv), .loUv(loUv),
  .hoOn(hoOn), .loOn(loOn)
);

// File: tb/sim_leg_gate_guard.sv
`timescale 1ns/1ps
module sim_leg_gate_guard;

  localparam int DEAD = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hiCmdN = 1'b1, loCmdN = 1'b1, enable = 1'b1, fault = 1'b0;
  logic hiUv = 1'b0, loUv = 1'b0;
  logic hoOn, loOn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit bothSeen = 1'b0;

  always #4 clk = ~clk;

  leg_gate_guard #(.DEAD_CYC(DEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .hiCmdN(hiCmdN), .loCmdN(loCmdN),
    .enable(enable), .fault(fault), .hiUv(hiUv), .loUv(loUv),
    .hoOn(hoOn), .loOn(loOn)
  );

  always @(negedge clk) begin
    cycles++;
    if (hoOn && loOn) bothSeen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitOut(input logic eh, input logic el, input int maxc, output int took);
    took = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (hoOn == eh && loOn == el) begin
        took = i;
        break;
      end
    end
  endtask

  task automatic settle();
    @(negedge clk);
    hiCmdN = 1'b1; loCmdN = 1'b1; enable = 1'b1; fault = 1'b0; hiUv = 1'b0; loUv = 1'b0;
    idle(DEAD + 10);
  endtask

  task automatic testReset();
    int t;
    idle(3);
    check(!hoOn && !loOn, "R1 outputs in reset", {hoOn, loOn}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(DEAD + 5);
    check(!hoOn && !loOn, "R1 outputs after reset", {hoOn, loOn}, 0);
  endtask

  task automatic testLowFollow();
    int t;
    @(negedge clk); loCmdN = 1'b0;
    waitOut(1'b0, 1'b1, 4, t);
    check(t > 0, "R5 lo on latency", t, 3);
    @(negedge clk); loCmdN = 1'b1;
    waitOut(1'b0, 1'b0, 4, t);
    check(t > 0, "R5 lo off latency", t, 3);
    settle();
  endtask

  task automatic testHiArm();
    int t;
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 5, t);
    check(t > 0, "R5 hi on after arming edge", t, 4);
    settle();
  endtask

  task automatic testHandoff();
    int t;
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 5, t);
    @(negedge clk); hiCmdN = 1'b1; loCmdN = 1'b0;
    waitOut(1'b0, 1'b0, 5, t);
    waitOut(1'b0, 1'b1, DEAD + 5, t);
    check(t == DEAD, "R3 hi->lo dead gap", t, DEAD);
    @(negedge clk); hiCmdN = 1'b0; loCmdN = 1'b1;
    waitOut(1'b0, 1'b0, 5, t);
    waitOut(1'b1, 1'b0, DEAD + 5, t);
    check(t == DEAD, "R3 lo->hi dead gap", t, DEAD);
    settle();
  endtask

  task automatic testConflict();
    int t;
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 5, t);
    @(negedge clk); loCmdN = 1'b0;
    idle(4);
    check(!hoOn && !loOn, "R2 conflict both off", {hoOn, loOn}, 0);
    idle(2 * DEAD);
    check(!hoOn && !loOn, "R2 conflict held off", {hoOn, loOn}, 0);
    @(negedge clk); loCmdN = 1'b1;
    waitOut(1'b1, 1'b0, DEAD + 6, t);
    check(t >= DEAD && t <= DEAD + 4, "R4 release to hi", t, DEAD + 2);
    settle();
  endtask

  task automatic testEnable();
    int t;
    @(negedge clk); loCmdN = 1'b0;
    waitOut(1'b0, 1'b1, 4, t);
    @(negedge clk); enable = 1'b0;
    idle(4);
    check(!loOn && !hoOn, "R6 enable low off", {hoOn, loOn}, 0);
    idle(DEAD);
    check(!loOn, "R6 enable low held", loOn, 0);
    @(negedge clk); enable = 1'b1;
    waitOut(1'b0, 1'b1, DEAD + 5, t);
    check(t > 0, "R6 enable restored follow", t, 3);
    settle();
  endtask

  task automatic testFault();
    int t;
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 5, t);
    @(negedge clk); fault = 1'b1;
    idle(4);
    check(!hoOn && !loOn, "R7 fault off", {hoOn, loOn}, 0);
    idle(DEAD);
    @(negedge clk); fault = 1'b0;
    waitOut(1'b1, 1'b0, DEAD + 5, t);
    check(t > 0, "R7 hi returns after fault", t, 3);
    settle();
  endtask

  task automatic testLoUv();
    int t;
    @(negedge clk); loCmdN = 1'b0;
    waitOut(1'b0, 1'b1, 4, t);
    @(negedge clk); loUv = 1'b1;
    idle(4);
    check(!hoOn && !loOn, "R8 lo uv off", {hoOn, loOn}, 0);
    idle(2 * DEAD);
    @(negedge clk); loUv = 1'b0;
    waitOut(1'b0, 1'b1, 4, t);
    check(t > 0, "R8 lo follows level after uv", t, 3);
    settle();
  endtask

  task automatic testHiUv();
    int t;
    @(negedge clk); loCmdN = 1'b0;
    waitOut(1'b0, 1'b1, 4, t);
    @(negedge clk); hiUv = 1'b1;
    idle(10);
    check(loOn == 1'b1, "R9 lo untouched by hi uv", loOn, 1);
    @(negedge clk); hiUv = 1'b0; loCmdN = 1'b1;
    idle(DEAD + 10);
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 6, t);
    @(negedge clk); hiUv = 1'b1;
    idle(4);
    check(!hoOn, "R9 hi uv forces off", hoOn, 0);
    @(negedge clk); hiUv = 1'b0;
    idle(2 * DEAD);
    check(!hoOn, "R9 stays off without new edge", hoOn, 0);
    @(negedge clk); hiCmdN = 1'b1;
    idle(4);
    @(negedge clk); hiCmdN = 1'b0;
    waitOut(1'b1, 1'b0, 6, t);
    check(t > 0, "R9 re-armed by new edge", t, 4);
    settle();
  endtask

  initial begin
    fork
      begin
        testReset();
        testLowFollow();
        testHiArm();
        testHandoff();
        testConflict();
        testEnable();
        testFault();
        testLoUv();
        testHiUv();
        check(!bothSeen, "R2 never both on", int'(bothSeen), 0);
      end
      begin
        wait (cycles >= 20000);
        check(1'b0, "watchdog", cycles, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule